// File: doc/BRIEF.md
# Configuration Access Request Engine

This block lets a host processor issue one PCIe configuration read or write at a time. Software sets up the request through a small memory-mapped register window and then sets a start bit. The engine presents the request on a valid/ready interface to the link side. It then waits for a single-cycle completion and records the outcome in a status word that software can poll.

The window holds these registers: a control word with a four-bit transaction kind and an address-translation bypass flag, a two-word target address, write data and byte enables, captured read data, a start bit and a done flag. Start stays set while the request is outstanding. The done flag is raised when the completion returns and is cleared by writing 1 to it. Packet formatting and link management belong to neighbouring logic.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, start, done flag, status word and read data all read 0 and `reqValid` is low.
- R2: The window begins at `WIN_BASE` (0x4000). Its word offsets are: control 0x00, status 0x04, address low 0x08, address high 0x0C, write data 0x10, byte enables 0x14, read data 0x18, start 0x1C, done flag 0x20. Control bits 3:0, control bit 24, both address words, write data and byte-enable bits 3:0 read back as written. Reads outside the window return 0.
- R3: Writing 1 to start bit 0 while idle raises `reqValid` in the next cycle. `reqValid` and the request fields stay constant until `reqReady` is sampled high. The request carries control bits 3:0 as `reqType`, the address as {high word, low word with bits 1:0 forced to 0}, the write data and the byte enables.
- R4: Start bit 0 reads 1 from launch until a completion is accepted and reads 0 afterwards. Completions are accepted only after the request handshake.
- R5: Done flag bit 0 is set by an accepted completion. Writing 1 to it clears it; writing 0 leaves it unchanged.
- R6: On an accepted completion, status bits 9:7 take the returned code (0 OK, 1 unsupported request, 2 retry, 4 abort) and bit 11 takes the returned error flag. Bit 10 is set when the kind is a configuration access (0x8 to 0xB) and cleared otherwise.
- R7: Read data is updated only when a read kind (0x8 or 0x9) completes with code 0 and the error flag clear. In every other case it keeps its previous value.
- R8: While a request is outstanding, writes to start, control, address, write data and byte enables have no effect. A start written while busy does not cause a second request.
- R9: Control bit 24 is held and read back, but does not change the request type or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register bus byte address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | DATA_W | Register write data |
| busRdData | output | DATA_W | Register read data (combinational on busAddr) |
| reqValid | output | 1 | Request present |
| reqReady | input | 1 | Request accepted by link side |
| reqType | output | 4 | Transaction kind |
| reqAddr | output | 2*DATA_W | Target address, bits 1:0 zero |
| reqData | output | DATA_W | Write payload |
| reqStrb | output | DATA_W/8 | Byte enables |
| cplValid | input | 1 | Single-cycle completion strobe |
| cplStatus | input | 3 | Completion code |
| cplErr | input | 1 | Completion error flag |
| cplData | input | DATA_W | Completion read data |

## Verification
The bench builds the engine with its defaults: a 32-bit data path, a 20-bit bus address and the window at 0x4000. These values put the status bit positions, control bit 24 and the two-word address within reach. The bench's responder varies the delay before `reqReady` and before the completion from vector to vector. This exercises a request held over several cycles and register traffic during the busy window. The vector set covers every completion code, the error flag, posted and non-posted kinds, and reads that must leave the data unchanged.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } pioState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;     // a request is outstanding
    logic capture;  // completion accepted this cycle
  } pioStrobe_t;

  localparam int OFF_W = 6;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_ADRLO = 6'h08;
  localparam logic [OFF_W-1:0] OFF_ADRHI = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_WDAT  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_STRB  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_RDAT  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_START = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DONE  = 6'h20;

  localparam int CODE_LSB  = 7;
  localparam int NP_BIT    = 10;
  localparam int ERR_BIT   = 11;
  localparam int BYPASS_BIT = 24;

  function automatic logic isCfgKind(input logic [3:0] kind);
    return kind[3:2] == 2'b10;
  endfunction

  function automatic logic isReadKind(input logic [3:0] kind);
    return kind[3:1] == 3'b100;
  endfunction

endpackage

// File: rtl/cfg_pio_ctrl.sv
module cfg_pio_ctrl
  import cfg_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic       reqReady,
  input  logic       cplValid,
  output logic       reqValid,
  output pioStrobe_t strobes
);

  pioState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startWr)  stateNext = ST_REQ;
      ST_REQ:  if (reqReady) stateNext = ST_WAIT;
      ST_WAIT: if (cplValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqValid        = (state == ST_REQ);
  assign strobes.busy    = (state != ST_IDLE);
  assign strobes.capture = (state == ST_WAIT) && cplValid;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid); // R3

  AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(startWr)); // R3

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.busy); // R4

  AST_NO_EARLY_CPL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !strobes.capture); // R4

endmodule

// File: rtl/cfg_pio_dpath.sv
module cfg_pio_dpath
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int WIN_BASE = 'h4000,
  localparam int STRB_W  = DATA_W / 8,
  localparam int WIN_SPAN = 1 << OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  pioStrobe_t          strobes,
  output logic                startWr,
  input  logic [2:0]          cplStatus,
  input  logic                cplErr,
  input  logic [DATA_W-1:0]   cplData,
  output logic [3:0]          reqType,
  output logic [2*DATA_W-1:0] reqAddr,
  output logic [DATA_W-1:0]   reqData,
  output logic [STRB_W-1:0]   reqStrb
);

  logic [ADDR_W-1:0] relAddr;
  logic              inWin;
  logic [OFF_W-1:0]  off;
  logic              cfgWr;  // write to a request field, allowed only when idle

  assign relAddr = busAddr - ADDR_W'(WIN_BASE);
  assign inWin   = relAddr < ADDR_W'(WIN_SPAN);
  assign off     = relAddr[OFF_W-1:0];
  assign cfgWr   = busWrEn && inWin && !strobes.busy;
  assign startWr = cfgWr && (off == OFF_START) && busWrData[0];

  logic [3:0]        kindReg;
  logic              bypassReg;
  logic [DATA_W-1:0] adrLoReg, adrHiReg, wdatReg, rdatReg;
  logic [STRB_W-1:0] strbReg;
  logic [2:0]        codeReg;
  logic              errReg, npReg, doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindReg   <= '0;
      bypassReg <= 1'b0;
      adrLoReg  <= '0;
      adrHiReg  <= '0;
      wdatReg   <= '0;
      strbReg   <= '0;
    end else if (cfgWr) begin
      unique case (off)
        OFF_CTRL: begin
          kindReg   <= busWrData[3:0];
          bypassReg <= busWrData[BYPASS_BIT];
        end
        OFF_ADRLO: adrLoReg <= busWrData;
        OFF_ADRHI: adrHiReg <= busWrData;
        OFF_WDAT:  wdatReg  <= busWrData;
        OFF_STRB:  strbReg  <= busWrData[STRB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      errReg  <= 1'b0;
      npReg   <= 1'b0;
      rdatReg <= '0;
    end else if (strobes.capture) begin
      codeReg <= cplStatus;
      errReg  <= cplErr;
      npReg   <= isCfgKind(kindReg);
      if (isReadKind(kindReg) && cplStatus == 3'd0 && !cplErr)
        rdatReg <= cplData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      doneReg <= 1'b0;
    else if (strobes.capture)
      doneReg <= 1'b1;
    else if (busWrEn && inWin && off == OFF_DONE && busWrData[0])
      doneReg <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    if (inWin) begin
      unique case (off)
        OFF_CTRL: begin
          busRdData[3:0]        = kindReg;
          busRdData[BYPASS_BIT] = bypassReg;
        end
        OFF_STAT: begin
          busRdData[CODE_LSB +: 3] = codeReg;
          busRdData[NP_BIT]        = npReg;
          busRdData[ERR_BIT]       = errReg;
        end
        OFF_ADRLO: busRdData = adrLoReg;
        OFF_ADRHI: busRdData = adrHiReg;
        OFF_WDAT:  busRdData = wdatReg;
        OFF_STRB:  busRdData[STRB_W-1:0] = strbReg;
        OFF_RDAT:  busRdData = rdatReg;
        OFF_START: busRdData[0] = strobes.busy;
        OFF_DONE:  busRdData[0] = doneReg;
        default: ;
      endcase
    end
  end

  assign reqType = kindReg;
  assign reqAddr = {adrHiReg, adrLoReg[DATA_W-1:2], 2'b00};
  assign reqData = wdatReg;
  assign reqStrb = strbReg;

  AST_ISR_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> doneReg); // R5

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> $stable(reqAddr) && $stable(reqType) && $stable(reqData)); // R8

  AST_RD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.capture && isReadKind(kindReg) && cplStatus == 3'd0 && !cplErr)
      |=> $stable(rdatReg)); // R7

  AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(codeReg) && $stable(errReg)); // R6

endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int WIN_BASE = 'h4000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  reqValid,
  input  logic                  reqReady,
  output logic [3:0]            reqType,
  output logic [2*DATA_W-1:0]   reqAddr,
  output logic [DATA_W-1:0]     reqData,
  output logic [DATA_W/8-1:0]   reqStrb,
  input  logic                  cplValid,
  input  logic [2:0]            cplStatus,
  input  logic                  cplErr,
  input  logic [DATA_W-1:0]     cplData
);

  pioStrobe_t strobes;
  logic       startWr;

  cfg_pio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startWr  (startWr),
    .reqReady (reqReady),
    .cplValid (cplValid),
    .reqValid (reqValid),
    .strobes  (strobes)
  );

  cfg_pio_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .strobes   (strobes),
    .startWr   (startWr),
    .cplStatus (cplStatus),
    .cplErr    (cplErr),
    .cplData   (cplData),
    .reqType   (reqType),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqStrb   (reqStrb)
  );

endmodule

// File: tb/tb_cfg_pio_engine.sv
module tb_cfg_pio_engine;

  localparam logic [19:0] WB = 20'h04000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [3:0]  reqType;
  logic [63:0] reqAddr;
  logic [31:0] reqData;
  logic [3:0]  reqStrb;
  logic        cplValid = 1'b0;
  logic [2:0]  cplStatus = '0;
  logic        cplErr = 1'b0;
  logic [31:0] cplData = '0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_pio_engine dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqType(reqType), .reqAddr(reqAddr),
    .reqData(reqData), .reqStrb(reqStrb), .cplValid(cplValid),
    .cplStatus(cplStatus), .cplErr(cplErr), .cplData(cplData)
  );

  typedef struct packed {
    logic [3:0]  kind;
    logic [31:0] addr;
    logic [31:0] wdat;
    logic [3:0]  strb;
    logic [2:0]  code;
    logic        err;
    logic [31:0] cdat;
    logic [31:0] expStat;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'h8, 32'h0010_0007, 32'h0,         4'hF, 3'd0, 1'b0, 32'h11AB_1B4B, 32'h400, 32'h11AB_1B4B},
    '{4'h9, 32'h0128_8010, 32'h0,         4'hF, 3'd1, 1'b0, 32'hDEAD_BEEF, 32'h480, 32'h11AB_1B4B},
    '{4'hA, 32'h0000_0006, 32'h5500_0000, 4'hC, 3'd0, 1'b0, 32'h0000_0055, 32'h400, 32'h11AB_1B4B},
    '{4'h8, 32'h0020_0000, 32'h0,         4'hF, 3'd2, 1'b0, 32'h1111_2222, 32'h500, 32'h11AB_1B4B},
    '{4'h8, 32'h0030_0004, 32'h0,         4'hF, 3'd0, 1'b1, 32'h0000_0099, 32'hC00, 32'h11AB_1B4B},
    '{4'hB, 32'h0FF1_F3FD, 32'h0000_00A5, 4'h2, 3'd4, 1'b0, 32'h0,         32'h600, 32'h11AB_1B4B},
    '{4'h9, 32'h0040_8100, 32'h0,         4'hF, 3'd0, 1'b0, 32'hCAFE_F00D, 32'h400, 32'hCAFE_F00D},
    '{4'h4, 32'h0000_1000, 32'h0,         4'hF, 3'd0, 1'b0, 32'h0000_1234, 32'h000, 32'hCAFE_F00D}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk);
    busAddr = WB + 20'(off);
    busWrData = d;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] off, output logic [31:0] d);
    busAddr = WB + 20'(off);
    #1;
    d = busRdData;
  endtask

  // wait dly cycles with ready low (request must hold), then handshake
  task automatic handshake(input int dly);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R3 reqValid held", 64'(reqValid), 64'd1);
    end
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
  endtask

  task automatic complete(input int dly, input logic [2:0] c, input logic e, input logic [31:0] d);
    for (int k = 0; k < dly; k++) @(negedge clk);
    cplValid = 1'b1; cplStatus = c; cplErr = e; cplData = d;
    @(negedge clk);
    cplValid = 1'b0; cplStatus = '0; cplErr = 1'b0; cplData = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(6'h1C, rd); chk("R1 start", 64'(rd), 0);
    busRd(6'h20, rd); chk("R1 done", 64'(rd), 0);
    busRd(6'h04, rd); chk("R1 status", 64'(rd), 0);
    busRd(6'h18, rd); chk("R1 rdata", 64'(rd), 0);
    chk("R1 reqValid", 64'(reqValid), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      busWr(6'h00, {28'h0, v.kind});
      busWr(6'h08, v.addr);
      busWr(6'h0C, 32'(i));
      busWr(6'h10, v.wdat);
      busWr(6'h14, {28'h0, v.strb});
      busWr(6'h20, 32'h1);
      busWr(6'h1C, 32'h1);
      chk("R3 reqValid after start", 64'(reqValid), 1);
      chk("R3 reqType", 64'(reqType), 64'(v.kind));
      chk("R3 reqAddr", reqAddr, {32'(i), v.addr[31:2], 2'b00});
      chk("R3 reqData", 64'(reqData), 64'(v.wdat));
      chk("R3 reqStrb", 64'(reqStrb), 64'(v.strb));
      handshake(i % 3);
      chk("R3 reqValid drop", 64'(reqValid), 0);
      busRd(6'h1C, rd); chk("R4 start busy", 64'(rd), 1);
      complete(i % 2, v.code, v.err, v.cdat);
      busRd(6'h1C, rd); chk("R4 start cleared", 64'(rd), 0);
      busRd(6'h20, rd); chk("R5 done set", 64'(rd), 1);
      busRd(6'h04, rd); chk("R6 status", 64'(rd), 64'(v.expStat));
      busRd(6'h18, rd); chk("R7 rdata", 64'(rd), 64'(v.expRd));
    end

    // R5 write-0 keeps, write-1 clears
    busWr(6'h20, 32'h0);
    busRd(6'h20, rd); chk("R5 done kept on write 0", 64'(rd), 1);
    busWr(6'h20, 32'h1);
    busRd(6'h20, rd); chk("R5 done cleared", 64'(rd), 0);

    // R2 readback and out-of-window read
    busRd(6'h0C, rd); chk("R2 addr high", 64'(rd), 64'(NV - 1));
    busRd(6'h14, rd); chk("R2 strobe", 64'(rd), 64'hF);
    busAddr = 20'h03FFC; #1; chk("R2 outside window", 64'(busRdData), 0);

    // R9 bypass bit held, no effect on request
    busWr(6'h00, 32'h0100_0009);
    busRd(6'h00, rd); chk("R9 ctrl readback", 64'(rd), 64'h0100_0009);
    busWr(6'h08, 32'h0050_0008);
    busWr(6'h0C, 32'h0);
    busWr(6'h1C, 32'h1);
    chk("R9 reqType", 64'(reqType), 64'h9);
    chk("R9 reqAddr", reqAddr, 64'h0050_0008);
    handshake(1);

    // R8 writes while busy ignored
    busWr(6'h08, 32'hFFFF_FFFF);
    busWr(6'h00, 32'h0000_000A);
    busWr(6'h1C, 32'h1);
    busRd(6'h08, rd); chk("R8 addr low kept", 64'(rd), 64'h0050_0008);
    busRd(6'h00, rd); chk("R8 ctrl kept", 64'(rd), 64'h0100_0009);
    chk("R8 reqAddr kept", reqAddr, 64'h0050_0008);
    complete(0, 3'd0, 1'b0, 32'h7777_0000);
    busRd(6'h18, rd); chk("R7 rdata after bypass read", 64'(rd), 64'h7777_0000);
    @(negedge clk);
    chk("R8 no second request", 64'(reqValid), 0);
    busRd(6'h1C, rd); chk("R8 start idle", 64'(rd), 0);

    // R4 completion before handshake ignored
    busWr(6'h1C, 32'h1);
    complete(0, 3'd1, 1'b1, 32'h0);
    chk("R4 early cpl ignored", 64'(reqValid), 1);
    busRd(6'h04, rd); chk("R4 status unchanged", 64'(rd), 64'h400);
    handshake(0);
    complete(0, 3'd0, 1'b0, 32'h0000_ABCD);
    busRd(6'h18, rd); chk("R7 rdata final", 64'(rd), 64'h0000_ABCD);

    // R1 reset again mid-state
    busWr(6'h1C, 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reqValid after reset", 64'(reqValid), 0);
    busRd(6'h18, rd); chk("R1 rdata after reset", 64'(rd), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule